// File: doc/BRIEF.md
# Ready-Latency Streaming Packet Source

This block sits on the application side of a 64-bit packet stream. The sink on the other side uses a ready signal with a fixed latency. A beat may only be put on the output in a cycle where the sink's ready was high a set number of cycles earlier. That number is two by default and three in the alternative build. Every beat presented under that rule counts as taken by the sink. No output handshake completes in the same cycle.

Packets enter through a zero-latency valid/ready port. Each beat carries a data word, start and end markers and a bad-packet flag. Accepted beats wait in a small buffer. A registered output stage takes one beat from the buffer in each cycle that the delayed ready permits. In every other cycle it holds its last word. The ready history is cleared by reset, so nothing is sent until ready has been observed for the full latency.

The input side also watches the packet framing. A start marker inside an open packet, or an end marker without a packet open, raises a sticky error flag.

Top module: `rl_stream_source`

## Requirements
- R1: `src_valid` is high in a cycle only if `snk_ready` was high exactly `READY_LATENCY` cycles before that cycle (default 2).
- R2: After reset is released, `src_valid` stays low for at least `READY_LATENCY` cycles, whatever `snk_ready` did during or after reset.
- R3: In every cycle where `src_valid` is low, `src_data`, `src_sop`, `src_eop` and `src_err` keep the values they had in the previous cycle.
- R4: Each beat accepted at the input is presented exactly once, in acceptance order, with its data word, start flag, end flag and error flag unchanged.
- R5: `app_ready` is high exactly when the internal buffer (`BUF_DEPTH` entries) has a free entry. A beat is accepted at a rising edge where `app_valid` and `app_ready` are both high.
- R6: A beat accepted at edge E may first be presented in the cycle after edge E+1. From then on it is presented in the first cycle the delayed ready permits; no permitted cycle passes idle while a beat waits.
- R7: `frame_err` rises one edge after an accepted beat has `app_sop`=1 while a packet is open, or has `app_eop`=1 with `app_sop`=0 while no packet is open. A single beat with both flags set is a legal one-beat packet. Once set, the flag stays high until reset.
- R8: If `snk_ready` is held low, `src_valid` is low from `READY_LATENCY` cycles after the first low cycle until `READY_LATENCY` cycles after ready returns.
- R9: With `READY_LATENCY`=3 the same rules hold with a three-cycle delay, and beats still emerge in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| app_valid | input | 1 | Input beat is offered |
| app_ready | output | 1 | Input beat can be taken this cycle |
| app_data | input | DATA_W | Input data word |
| app_sop | input | 1 | Input beat starts a packet |
| app_eop | input | 1 | Input beat ends a packet |
| app_err | input | 1 | Input beat belongs to a bad packet |
| snk_ready | input | 1 | Sink ready, honoured READY_LATENCY cycles later |
| src_valid | output | 1 | Output beat presented and taken this cycle |
| src_data | output | DATA_W | Output data word |
| src_sop | output | 1 | Output start-of-packet |
| src_eop | output | 1 | Output end-of-packet |
| src_err | output | 1 | Output bad-packet flag |
| frame_err | output | 1 | Sticky input framing violation |

## Verification
Output validity in a cycle is decided by the ready value `READY_LATENCY` cycles earlier. A newly accepted beat needs two edges to reach the output. A framing violation shows on `frame_err` one edge after the offending beat. The bench keeps its own log of past ready values and a queue of accepted beats. At each falling edge it first advances this model by the rising edge just passed, using the inputs and `app_ready` it saw in the previous cycle. It then compares every output and applies new inputs. A second instance with a three-cycle latency is checked for the delayed permission and for in-order sequence numbers.

// File: rtl/rl_stream_pkg.sv
package rl_stream_pkg;

   localparam int unsigned RL_MAX_LATENCY = 8;
   localparam int unsigned RL_SIDE_W      = 3;

   typedef enum logic {
      FRM_IDLE = 1'b0,
      FRM_OPEN = 1'b1
   } frame_state_e;

   function automatic logic frame_violation(input frame_state_e st,
                                            input logic sop,
                                            input logic eop);
      return (sop && (st == FRM_OPEN)) || (eop && !sop && (st == FRM_IDLE));
   endfunction

   function automatic frame_state_e frame_next(input frame_state_e st,
                                               input logic sop,
                                               input logic eop);
      frame_state_e nxt;
      nxt = st;
      if (sop && !eop)
         nxt = FRM_OPEN;
      else if (eop)
         nxt = FRM_IDLE;
      return nxt;
   endfunction

endpackage

// File: rtl/rl_ready_history.sv
module rl_ready_history
   import rl_stream_pkg::*;
#(
   parameter int unsigned LATENCY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic snk_ready,
   output logic grant_next
);

   localparam int unsigned HIST_W = LATENCY - 1;

   generate
      if (LATENCY < 2 || LATENCY > RL_MAX_LATENCY) begin : g_bad_latency
         $error("rl_ready_history: LATENCY must lie between 2 and RL_MAX_LATENCY");
      end

      if (HIST_W == 1) begin : g_single
         logic seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               seen_q <= 1'b0;
            else
               seen_q <= snk_ready;
         end
         assign grant_next = seen_q;
      end else begin : g_chain
         logic [HIST_W-1:0] seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               seen_q <= '0;
            else
               seen_q <= {seen_q[HIST_W-2:0], snk_ready};
         end
         assign grant_next = seen_q[HIST_W-1];
      end
   endgenerate

endmodule

// File: rtl/rl_beat_buffer.sv
module rl_beat_buffer #(
   parameter int unsigned WIDTH = 67,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wr_beat,
   input  logic             pop,
   output logic [WIDTH-1:0] rd_beat,
   output logic             empty,
   output logic             full
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("rl_beat_buffer: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic [WIDTH-1:0] slot_q;
         logic             held_q;

         always_ff @(posedge clk) begin
            if (push)
               slot_q <= wr_beat;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               held_q <= 1'b0;
            else if (push)
               held_q <= 1'b1;
            else if (pop)
               held_q <= 1'b0;
         end

         assign rd_beat = slot_q;
         assign empty   = !held_q;
         assign full    = held_q;
      end else begin : g_ring
         localparam int unsigned AW = $clog2(DEPTH);
         localparam int unsigned CW = $clog2(DEPTH + 1);

         logic [WIDTH-1:0] mem [DEPTH];
         logic [AW-1:0]    wr_ptr_q;
         logic [AW-1:0]    rd_ptr_q;
         logic [CW-1:0]    count_q;

         function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
            return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
         endfunction

         always_ff @(posedge clk) begin
            if (push)
               mem[wr_ptr_q] <= wr_beat;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_ptr_q <= '0;
               rd_ptr_q <= '0;
               count_q  <= '0;
            end else begin
               if (push)
                  wr_ptr_q <= ptr_step(wr_ptr_q);
               if (pop)
                  rd_ptr_q <= ptr_step(rd_ptr_q);
               case ({push, pop})
                  2'b10:   count_q <= count_q + CW'(1);
                  2'b01:   count_q <= count_q - CW'(1);
                  default: count_q <= count_q;
               endcase
            end
         end

         assign rd_beat = mem[rd_ptr_q];
         assign empty   = (count_q == '0);
         assign full    = (count_q == CW'(DEPTH));
      end
   endgenerate

endmodule

// File: rtl/rl_frame_monitor.sv
module rl_frame_monitor
   import rl_stream_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic sop,
   input  logic eop,
   output logic frame_err
);

   frame_state_e state_q;
   logic         err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FRM_IDLE;
         err_q   <= 1'b0;
      end else if (accept) begin
         state_q <= frame_next(state_q, sop, eop);
         if (frame_violation(state_q, sop, eop))
            err_q <= 1'b1;
      end
   end

   assign frame_err = err_q;

endmodule

// File: rtl/rl_stream_source.sv
module rl_stream_source
   import rl_stream_pkg::*;
#(
   parameter int unsigned DATA_W        = 64,
   parameter int unsigned READY_LATENCY = 2,
   parameter int unsigned BUF_DEPTH     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              app_valid,
   output logic              app_ready,
   input  logic [DATA_W-1:0] app_data,
   input  logic              app_sop,
   input  logic              app_eop,
   input  logic              app_err,
   input  logic              snk_ready,
   output logic              src_valid,
   output logic [DATA_W-1:0] src_data,
   output logic              src_sop,
   output logic              src_eop,
   output logic              src_err,
   output logic              frame_err
);

   localparam int unsigned BEAT_W = DATA_W + RL_SIDE_W;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("rl_stream_source: DATA_W must be positive");
      end
   endgenerate

   logic              grant_next;
   logic              buf_empty;
   logic              buf_full;
   logic              take_in;
   logic              send_out;
   logic [BEAT_W-1:0] in_beat;
   logic [BEAT_W-1:0] head_beat;
   logic [BEAT_W-1:0] out_beat_q;
   logic              out_valid_q;

   assign in_beat   = {app_err, app_eop, app_sop, app_data};
   assign app_ready = !buf_full;
   assign take_in   = app_valid && !buf_full;
   assign send_out  = grant_next && !buf_empty;

   rl_ready_history #(
      .LATENCY (READY_LATENCY)
   ) u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .snk_ready  (snk_ready),
      .grant_next (grant_next)
   );

   rl_beat_buffer #(
      .WIDTH (BEAT_W),
      .DEPTH (BUF_DEPTH)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (take_in),
      .wr_beat (in_beat),
      .pop     (send_out),
      .rd_beat (head_beat),
      .empty   (buf_empty),
      .full    (buf_full)
   );

   rl_frame_monitor u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (take_in),
      .sop       (app_sop),
      .eop       (app_eop),
      .frame_err (frame_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_q <= 1'b0;
         out_beat_q  <= '0;
      end else begin
         out_valid_q <= send_out;
         if (send_out)
            out_beat_q <= head_beat;
      end
   end

   assign src_valid = out_valid_q;
   assign src_data  = out_beat_q[DATA_W-1:0];
   assign src_sop   = out_beat_q[DATA_W];
   assign src_eop   = out_beat_q[DATA_W+1];
   assign src_err   = out_beat_q[DATA_W+2];

endmodule

// File: rtl/rl_stream_source_chk.sv
module rl_stream_source_chk #(
   parameter int unsigned LATENCY = 2,
   parameter int unsigned DATA_W  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              app_valid,
   input logic              app_ready,
   input logic              snk_ready,
   input logic              src_valid,
   input logic [DATA_W-1:0] src_data,
   input logic              src_sop,
   input logic              src_eop,
   input logic              src_err,
   input logic              frame_err
);

   assert_valid_needs_old_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      src_valid |-> $past(snk_ready, LATENCY));

   assert_quiet_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |=> !src_valid);

   assert_hold_while_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !src_valid |-> ($stable(src_data) && $stable(src_sop) && $stable(src_eop) && $stable(src_err)));

   assert_ready_drop_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(app_ready) |-> $past(app_valid));

   assert_frame_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

endmodule

bind rl_stream_source rl_stream_source_chk #(
   .LATENCY (READY_LATENCY),
   .DATA_W  (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .app_valid (app_valid),
   .app_ready (app_ready),
   .snk_ready (snk_ready),
   .src_valid (src_valid),
   .src_data  (src_data),
   .src_sop   (src_sop),
   .src_eop   (src_eop),
   .src_err   (src_err),
   .frame_err (frame_err)
);

// File: tb/sim_rl_stream_source.sv
`timescale 1ns/1ps
module sim_rl_stream_source;

   localparam int LAT0   = 2;
   localparam int DEPTH0 = 4;
   localparam int LAT1   = 3;
   localparam int DEPTH1 = 2;

   localparam int STALL_START = 2600;
   localparam int STALL_END   = 2700;
   localparam int GEN_STOP    = 3200;
   localparam int ERR_CYC     = 3300;
   localparam int TOTAL       = 3360;

   typedef struct packed {
      logic        err;
      logic        eop;
      logic        sop;
      logic [63:0] data;
   } beat_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        app_valid;
   logic        app_ready;
   logic [63:0] app_data;
   logic        app_sop, app_eop, app_err;
   logic        snk_ready;
   logic        src_valid;
   logic [63:0] src_data;
   logic        src_sop, src_eop, src_err;
   logic        frame_err;

   logic        app_valid1;
   logic        app_ready1;
   logic [63:0] app_data1;
   logic        src_valid1;
   logic [63:0] src_data1;
   logic        src_sop1, src_eop1, src_err1;
   logic        frame_err1;

   always #5 clk = ~clk;

   rl_stream_source #(.DATA_W(64), .READY_LATENCY(LAT0), .BUF_DEPTH(DEPTH0)) u0 (
      .clk(clk), .rst_n(rst_n),
      .app_valid(app_valid), .app_ready(app_ready), .app_data(app_data),
      .app_sop(app_sop), .app_eop(app_eop), .app_err(app_err),
      .snk_ready(snk_ready),
      .src_valid(src_valid), .src_data(src_data), .src_sop(src_sop),
      .src_eop(src_eop), .src_err(src_err), .frame_err(frame_err)
   );

   rl_stream_source #(.DATA_W(64), .READY_LATENCY(LAT1), .BUF_DEPTH(DEPTH1)) u1 (
      .clk(clk), .rst_n(rst_n),
      .app_valid(app_valid1), .app_ready(app_ready1), .app_data(app_data1),
      .app_sop(1'b1), .app_eop(1'b1), .app_err(1'b0),
      .snk_ready(snk_ready),
      .src_valid(src_valid1), .src_data(src_data1), .src_sop(src_sop1),
      .src_eop(src_eop1), .src_err(src_err1), .frame_err(frame_err1)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;

   beat_t q[$];
   beat_t exp_beat;
   bit    exp_valid;
   bit    rlog [4];
   bit    m_open, m_perr;
   bit    prev_rst, prev_ready, prev_acc, prev_acc1;
   beat_t prev_beat;
   int    since_rst;
   longint unsigned exp_seq1, drv_seq1;
   int    beats_in, beats_out, beats_out1;

   int    pkt_id, beat_idx, pkt_len;
   logic [31:0] beat_rand;
   int    ready_mode;

   task automatic check(input bit ok, input string req, input string what,
                        input longint unsigned act, input longint unsigned exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic new_packet();
      pkt_id++;
      beat_idx  = 0;
      pkt_len   = 1 + int'($urandom_range(0, 3));
      beat_rand = $urandom();
   endtask

   task automatic step(input int cyc);
      string r;
      // advance the model by the rising edge just passed
      if (!prev_rst) begin
         q.delete();
         exp_valid = 1'b0;
         exp_beat  = '0;
         for (int k = 0; k < 4; k++) rlog[k] = 1'b0;
         m_open    = 1'b0;
         m_perr    = 1'b0;
         since_rst = 0;
         exp_seq1  = 0;
      end else begin
         since_rst++;
         for (int k = 3; k > 0; k--) rlog[k] = rlog[k-1];
         rlog[0] = prev_ready;
         if (rlog[LAT0-1] && q.size() > 0) begin
            exp_valid = 1'b1;
            exp_beat  = q.pop_front();
         end else begin
            exp_valid = 1'b0;
         end
         if (prev_acc) begin
            q.push_back(prev_beat);
            beats_in++;
            if ((prev_beat.sop && m_open) || (prev_beat.eop && !prev_beat.sop && !m_open))
               m_perr = 1'b1;
            if (prev_beat.sop && !prev_beat.eop) m_open = 1'b1;
            else if (prev_beat.eop)              m_open = 1'b0;
         end
      end

      // compare lane 0 (latency 2)
      r = exp_valid ? "R6" : "R1";
      check(src_valid == exp_valid, r, "src_valid", 64'(src_valid), 64'(exp_valid));
      if (src_valid) beats_out++;
      r = exp_valid ? "R4" : "R3";
      check(src_data == exp_beat.data, r, "src_data", src_data, exp_beat.data);
      check(src_sop == exp_beat.sop, r, "src_sop", 64'(src_sop), 64'(exp_beat.sop));
      check(src_eop == exp_beat.eop, r, "src_eop", 64'(src_eop), 64'(exp_beat.eop));
      check(src_err == exp_beat.err, r, "src_err", 64'(src_err), 64'(exp_beat.err));
      check(app_ready == (q.size() < DEPTH0), "R5", "app_ready", 64'(app_ready), 64'(q.size() < DEPTH0));
      check(frame_err == m_perr, "R7", "frame_err", 64'(frame_err), 64'(m_perr));
      if (prev_rst && since_rst < LAT0)
         check(!src_valid, "R2", "src_valid after reset", 64'(src_valid), 64'd0);
      if (cyc >= STALL_START + LAT0 && cyc < STALL_END + LAT0)
         check(!src_valid, "R8", "src_valid during stall", 64'(src_valid), 64'd0);
      if (cyc == ERR_CYC)
         check(!frame_err, "R7", "frame_err before bad beat", 64'(frame_err), 64'd0);
      if (cyc == ERR_CYC + 1 || cyc == TOTAL - 1)
         check(frame_err, "R7", "frame_err after bad beat", 64'(frame_err), 64'd1);

      // compare lane 1 (latency 3)
      if (prev_rst && since_rst < LAT1)
         check(!src_valid1, "R9", "lane1 quiet after reset", 64'(src_valid1), 64'd0);
      if (src_valid1) begin
         check(rlog[LAT1-1], "R9", "lane1 valid without ready 3 cycles back", 64'(src_valid1), 64'(rlog[LAT1-1]));
         check(src_data1 == exp_seq1, "R9", "lane1 sequence", src_data1, exp_seq1);
         exp_seq1++;
         beats_out1++;
      end

      // drive inputs for the coming cycle
      rst_n = (cyc >= 4);
      if (prev_acc) begin
         if (beat_idx == pkt_len - 1) new_packet();
         else begin
            beat_idx++;
            beat_rand = $urandom();
         end
      end
      if (prev_acc1) drv_seq1++;

      if (cyc % 16 == 0) ready_mode = int'($urandom_range(0, 3));
      if (cyc < 200)                                   snk_ready = 1'b1;
      else if (cyc >= STALL_START && cyc < STALL_END)  snk_ready = 1'b0;
      else if (cyc >= GEN_STOP)                        snk_ready = 1'b1;
      else begin
         case (ready_mode)
            0:       snk_ready = ($urandom_range(0, 1) == 1);
            1:       snk_ready = ($urandom_range(0, 9) != 0);
            2:       snk_ready = cyc[0];
            default: snk_ready = ($urandom_range(0, 9) == 0);
         endcase
      end

      app_sop  = (beat_idx == 0);
      app_eop  = (beat_idx == pkt_len - 1);
      app_err  = (pkt_id % 5 == 3);
      app_data = {pkt_id[15:0], beat_idx[7:0], 8'h00, beat_rand};
      if (cyc < 4)
         app_valid = 1'b0;
      else if (cyc == ERR_CYC) begin
         app_valid = 1'b1;
         app_sop   = 1'b0;
         app_eop   = 1'b1;
         app_data  = 64'hBAD0_0000_0000_0001;
      end else if (cyc >= GEN_STOP && beat_idx == 0)
         app_valid = 1'b0;
      else if (cyc < 200)
         app_valid = 1'b1;
      else
         app_valid = ($urandom_range(0, 9) < 7);

      app_valid1 = (cyc >= 4);
      app_data1  = drv_seq1;

      prev_rst   = rst_n;
      prev_ready = snk_ready;
      prev_acc   = app_valid && app_ready;
      prev_acc1  = app_valid1 && app_ready1;
      prev_beat  = '{err: app_err, eop: app_eop, sop: app_sop, data: app_data};
   endtask

   initial begin
      rst_n = 1'b0; snk_ready = 1'b1;
      app_valid = 1'b0; app_data = '0; app_sop = 1'b0; app_eop = 1'b0; app_err = 1'b0;
      app_valid1 = 1'b0; app_data1 = '0;
      prev_rst = 1'b0; prev_ready = 1'b0; prev_acc = 1'b0; prev_acc1 = 1'b0; prev_beat = '0;
      beats_in = 0; beats_out = 0; beats_out1 = 0; drv_seq1 = 0; ready_mode = 0;
      pkt_id = 0;
      new_packet();
      for (int cyc = 1; cyc < TOTAL; cyc++) begin
         @(negedge clk);
         step(cyc);
      end
      // end-of-run checks: buffer drained, counts match, second lane moved data
      check(q.size() == 0, "R4", "beats left in model", 64'(q.size()), 64'd0);
      check(beats_in == beats_out, "R4", "beats out vs in", 64'(beats_out), 64'(beats_in));
      check(beats_out1 > 100, "R9", "lane1 beat count", 64'(beats_out1), 64'd101);
      check(!frame_err1, "R9", "lane1 frame_err", 64'(frame_err1), 64'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule